// File: doc/BRIEF.md
# Fast Register Memory Bus Responder

This block is a sixteen-word store of 36-bit words that acts as a memory-bus responder for one processor. It has several processor ports. Each port has its own cycle request, read and write qualifiers, bus address, write data and write-restart pulse. A static select input names the one port the block answers. The block ignores every other port. Only the low four bits of a bus address pick a word, and the block decodes no other address bits.

A cycle opens with a one-cycle request strobe while the block is idle. The block answers on the chosen port with a one-cycle address acknowledge.

- **Read:** the acknowledge comes with a read-restart pulse and the word on the read-data bus.
- **Write:** the block zeroes the word and arms a write phase. Any nonzero data the processor then puts on the bus is ORed into the word. This happens only while the processor is not asserting read.
- **Read-modify-write:** the block returns the old word, then clears it and arms the write phase in the same way.
- **Ending a cycle:** a pure read ends at once. Every other cycle ends on a write-restart pulse.

The controller is a three-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Free, waiting for a request. |
| `ST_HOLD` | A cycle with neither read nor write is in progress. |
| `ST_WRITE` | Active and armed for write. |

The transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| `accept-write` | `ST_IDLE` | `ST_WRITE` | Request with write set. |
| `accept-read` | `ST_IDLE` | `ST_IDLE` | Request with read only. |
| `accept-bare` | `ST_IDLE` | `ST_HOLD` | Request with neither read nor write. |
| `restart` | `ST_HOLD` or `ST_WRITE` | `ST_IDLE` | Write-restart pulse. |

Top module: `fast_reg_mem`

## Requirements
- R1: The block answers only the port whose index equals `port_sel_i`. Cycle requests, write data and write restarts on any other port produce no acknowledge or read restart, and they do not alter any stored word.
- R2: Only bits [3:0] of the selected port's bus address select the word. The upper address bits are ignored.
- R3: In `ST_IDLE`, a cycle request on the selected port is accepted. On the next clock edge, `addr_ack_o` is high for one cycle at that port's bit position only.
- R4: When the accepted request has read set, `rd_rs_o` pulses at that port's bit in the same cycle as the acknowledge, and `rdata_o` holds the addressed word. If write is clear, the cycle ends at once, so a request in the very next cycle is accepted again.
- R5: When the accepted request has write set, the addressed word becomes zero and the block enters `ST_WRITE`. A write restart with no data therefore leaves the word at zero.
- R6: In `ST_WRITE`, each cycle in which the selected port's read is low and its write data is nonzero ORs that data into the addressed word. Several such cycles accumulate.
- R7: A request with both read and write set returns the old word with read restart, and then clears the word. While read stays asserted, write data is not merged.
- R8: A write-restart pulse on the selected port returns the block from `ST_HOLD` or `ST_WRITE` to `ST_IDLE`. While a cycle is active, new cycle requests get no acknowledge. In `ST_IDLE`, a write restart has no effect.
- R9: While `rst_n` is low, the block is in `ST_IDLE` and both `addr_ack_o` and `rd_rs_o` are zero. Reset does not set the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| port_sel_i | input | SEL_W | Index of the one port answered |
| cyc_req_i | input | NPORT | One-cycle cycle request strobe, one bit per port |
| rd_req_i | input | NPORT | Read qualifier, one bit per port |
| wr_req_i | input | NPORT | Write qualifier, one bit per port |
| wr_rs_i | input | NPORT | Write-restart pulse, one bit per port |
| addr_i | input | NPORT*BUS_AW | Bus address, port p at [p*BUS_AW +: BUS_AW] |
| wdata_i | input | NPORT*DW | Write data, port p at [p*DW +: DW] |
| addr_ack_o | output | NPORT | Address acknowledge, one bit per port |
| rd_rs_o | output | NPORT | Read restart, one bit per port |
| rdata_o | output | DW | Word read in the last read cycle |

## Verification
The bench builds the block with its default parameters: four ports, an 18-bit bus address and 36-bit words. With four ports, the select can be moved between a port with stray traffic and the port it ignored. With the full bus address, addresses carrying upper bits can be aliased onto low words. The 36-bit words let the OR merge be shown with patterns in both halves of the word.

// File: rtl/fastmem_pkg.sv
package fastmem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_WRITE = 2'd2
    } fm_state_e;

endpackage

// File: rtl/fastmem_port_mux.sv
module fastmem_port_mux #(
    parameter int NPORT  = 4,
    parameter int BUS_AW = 18,
    parameter int DW     = 36,
    parameter int SEL_W  = 2
) (
    input  logic [SEL_W-1:0]        port_sel_i,
    input  logic [NPORT-1:0]        cyc_i,
    input  logic [NPORT-1:0]        rd_i,
    input  logic [NPORT-1:0]        wr_i,
    input  logic [NPORT-1:0]        wrs_i,
    input  logic [NPORT*BUS_AW-1:0] addr_i,
    input  logic [NPORT*DW-1:0]     wdata_i,
    output logic [NPORT-1:0]        hot_o,
    output logic                    s_cyc_o,
    output logic                    s_rd_o,
    output logic                    s_wr_o,
    output logic                    s_wrs_o,
    output logic [BUS_AW-1:0]       s_addr_o,
    output logic [DW-1:0]           s_wdata_o
);

    for (genvar p = 0; p < NPORT; p++) begin : g_hot
        assign hot_o[p] = (port_sel_i == SEL_W'(p));
    end

    always_comb begin
        s_cyc_o   = 1'b0;
        s_rd_o    = 1'b0;
        s_wr_o    = 1'b0;
        s_wrs_o   = 1'b0;
        s_addr_o  = '0;
        s_wdata_o = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (hot_o[p]) begin
                s_cyc_o   = cyc_i[p];
                s_rd_o    = rd_i[p];
                s_wr_o    = wr_i[p];
                s_wrs_o   = wrs_i[p];
                s_addr_o  = addr_i[p*BUS_AW +: BUS_AW];
                s_wdata_o = wdata_i[p*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/fastmem_ctrl.sv
module fastmem_ctrl
    import fastmem_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      s_cyc_i,
    input  logic      s_rd_i,
    input  logic      s_wr_i,
    input  logic      s_wrs_i,
    input  logic      s_wdata_nz_i,
    output fm_state_e state_o,
    output logic      accept_o,
    output logic      clear_o,
    output logic      merge_o,
    output logic      ack_q_o,
    output logic      rdrs_q_o
);

    fm_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (s_cyc_i) begin
                    accept_o = 1'b1;
                    if (s_wr_i)      state_d = ST_WRITE;
                    else if (s_rd_i) state_d = ST_IDLE;
                    else             state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (s_wrs_i) state_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (s_wrs_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q_o  <= 1'b0;
            rdrs_q_o <= 1'b0;
        end else begin
            ack_q_o  <= accept_o;
            rdrs_q_o <= accept_o && s_rd_i;
        end
    end

    assign clear_o = accept_o && s_wr_i;
    assign merge_o = (state_q == ST_WRITE) && !s_rd_i && s_wdata_nz_i;
    assign state_o = state_q;

    // R8
    restart_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && s_wrs_i) |=> (state_q == ST_IDLE));

    // R4
    pure_read_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && s_cyc_i && s_rd_i && !s_wr_i) |=> (state_q == ST_IDLE));

    // R8
    idle_restart_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !s_cyc_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/fastmem_array.sv
module fastmem_array #(
    parameter int DW    = 36,
    parameter int AW    = 4,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic          rd_i,
    input  logic          clear_i,
    input  logic          merge_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else if (accept_i) addr_q <= addr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_o <= '0;
        else if (accept_i && rd_i) rdata_o <= mem[addr_i];
    end

    always_ff @(posedge clk) begin
        if (clear_i)      mem[addr_i] <= '0;
        else if (merge_i) mem[addr_q] <= mem[addr_q] | wdata_i;
    end

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && clear_i) |=> (mem[addr_q] == '0));

    // R6
    merge_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        merge_i |=> ((mem[addr_q] & $past(wdata_i)) == $past(wdata_i)));

endmodule

// File: rtl/fast_reg_mem.sv
module fast_reg_mem
    import fastmem_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int BUS_AW = 18,
    parameter int DW     = 36,
    parameter int AW     = 4,
    localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int DEPTH = 1 << AW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SEL_W-1:0]        port_sel_i,
    input  logic [NPORT-1:0]        cyc_req_i,
    input  logic [NPORT-1:0]        rd_req_i,
    input  logic [NPORT-1:0]        wr_req_i,
    input  logic [NPORT-1:0]        wr_rs_i,
    input  logic [NPORT*BUS_AW-1:0] addr_i,
    input  logic [NPORT*DW-1:0]     wdata_i,
    output logic [NPORT-1:0]        addr_ack_o,
    output logic [NPORT-1:0]        rd_rs_o,
    output logic [DW-1:0]           rdata_o
);

    logic [NPORT-1:0]  hot, hot_q;
    logic              s_cyc, s_rd, s_wr, s_wrs;
    logic [BUS_AW-1:0] s_addr;
    logic [DW-1:0]     s_wdata;
    fm_state_e         state;
    logic              accept, clear, merge, ack_q, rdrs_q;

    fastmem_port_mux #(
        .NPORT(NPORT), .BUS_AW(BUS_AW), .DW(DW), .SEL_W(SEL_W)
    ) u_mux (
        .port_sel_i(port_sel_i),
        .cyc_i(cyc_req_i),
        .rd_i(rd_req_i),
        .wr_i(wr_req_i),
        .wrs_i(wr_rs_i),
        .addr_i(addr_i),
        .wdata_i(wdata_i),
        .hot_o(hot),
        .s_cyc_o(s_cyc),
        .s_rd_o(s_rd),
        .s_wr_o(s_wr),
        .s_wrs_o(s_wrs),
        .s_addr_o(s_addr),
        .s_wdata_o(s_wdata)
    );

    fastmem_ctrl u_ctrl (
        .clk(clk),
        .rst_n(rst_n),
        .s_cyc_i(s_cyc),
        .s_rd_i(s_rd),
        .s_wr_i(s_wr),
        .s_wrs_i(s_wrs),
        .s_wdata_nz_i(|s_wdata),
        .state_o(state),
        .accept_o(accept),
        .clear_o(clear),
        .merge_o(merge),
        .ack_q_o(ack_q),
        .rdrs_q_o(rdrs_q)
    );

    fastmem_array #(
        .DW(DW), .AW(AW), .DEPTH(DEPTH)
    ) u_array (
        .clk(clk),
        .rst_n(rst_n),
        .accept_i(accept),
        .rd_i(s_rd),
        .clear_i(clear),
        .merge_i(merge),
        .addr_i(s_addr[AW-1:0]),
        .wdata_i(s_wdata),
        .rdata_o(rdata_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hot_q <= '0;
        else if (accept) hot_q <= hot;
    end

    assign addr_ack_o = {NPORT{ack_q}}  & hot_q;
    assign rd_rs_o    = {NPORT{rdrs_q}} & hot_q;

    // R1
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(addr_ack_o));

    // R3
    ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|addr_ack_o) |-> $past(|(cyc_req_i & hot)));

    // R4
    rdrs_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_rs_o) |-> ((rd_rs_o & ~addr_ack_o) == '0));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (addr_ack_o == '0 && rd_rs_o == '0));

    // R8
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (addr_ack_o == '0));

endmodule

// File: tb/fast_reg_mem_test.sv
module fast_reg_mem_test;

    localparam int CLK_PERIOD = 10;
    localparam int NPORT  = 4;
    localparam int BUS_AW = 18;
    localparam int DW     = 36;
    localparam int SEL_W  = 2;

    // {4-bit word, 36-bit data}: written on port 0, read back later
    localparam logic [39:0] VEC [8] = '{
        {4'h0, 36'h0_0000_0001},
        {4'h1, 36'hF_FFFF_FFFF},
        {4'h2, 36'h5_5555_5555},
        {4'h4, 36'hA_AAAA_AAAA},
        {4'h7, 36'h8_0000_0000},
        {4'h9, 36'h1_2345_6789},
        {4'hC, 36'h0_00FF_FF00},
        {4'hF, 36'h7_6543_210F}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [SEL_W-1:0]        port_sel = '0;
    logic [NPORT-1:0]        cyc = '0, rd = '0, wr = '0, wrs = '0;
    logic [NPORT*BUS_AW-1:0] addr = '0;
    logic [NPORT*DW-1:0]     wdata = '0;
    logic [NPORT-1:0]        ack, rdrs;
    logic [DW-1:0]           rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    fast_reg_mem uut (
        .clk(clk), .rst_n(rst_n), .port_sel_i(port_sel),
        .cyc_req_i(cyc), .rd_req_i(rd), .wr_req_i(wr), .wr_rs_i(wrs),
        .addr_i(addr), .wdata_i(wdata),
        .addr_ack_o(ack), .rd_rs_o(rdrs), .rdata_o(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue a request strobe; sample acknowledge, restart and data after the edge.
    task automatic req(input int p, input logic [BUS_AW-1:0] a, input logic r, input logic w,
                       output logic [NPORT-1:0] ak, output logic [NPORT-1:0] rr,
                       output logic [DW-1:0] d);
        cyc[p] = 1'b1; rd[p] = r; wr[p] = w;
        addr[p*BUS_AW +: BUS_AW] = a;
        @(negedge clk);
        ak = ack; rr = rdrs; d = rdata;
        cyc[p] = 1'b0; wr[p] = 1'b0;
    endtask

    // One data-phase cycle; optionally with restart; rd level kept as given.
    task automatic data(input int p, input logic [DW-1:0] v, input logic r, input logic rs);
        wdata[p*DW +: DW] = v; rd[p] = r; wrs[p] = rs;
        @(negedge clk);
        wdata[p*DW +: DW] = '0; wrs[p] = 1'b0; rd[p] = 1'b0;
    endtask

    task automatic wr_word(input int p, input logic [BUS_AW-1:0] a, input logic [DW-1:0] v);
        logic [NPORT-1:0] ak, rr; logic [DW-1:0] d;
        req(p, a, 1'b0, 1'b1, ak, rr, d);
        data(p, v, 1'b0, 1'b1);
    endtask

    task automatic rd_word(input int p, input logic [BUS_AW-1:0] a, output logic [DW-1:0] d,
                           output logic [NPORT-1:0] ak);
        logic [NPORT-1:0] rr;
        req(p, a, 1'b1, 1'b0, ak, rr, d);
        rd[p] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [NPORT-1:0] ak, rr;
        logic [DW-1:0] d;

        repeat (3) @(negedge clk);
        // R9: outputs quiet during reset
        check("R9 ack in reset", 64'(ack), 64'h0);
        check("R9 rdrs in reset", 64'(rdrs), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table: write every vector, then read each back (R3, R4, R5, R6)
        for (int i = 0; i < 8; i++) begin
            req(0, 18'(VEC[i][39:36]), 1'b0, 1'b1, ak, rr, d);
            check("R3 write ack", 64'(ak), 64'h1);
            check("R4 no rdrs on write", 64'(rr), 64'h0);
            data(0, VEC[i][35:0], 1'b0, 1'b1);
        end
        for (int i = 0; i < 8; i++) begin
            rd_word(0, 18'(VEC[i][39:36]), d, ak);
            check("R4 read data", 64'(d), 64'(VEC[i][35:0]));
        end

        // R4: read restart with ack, and back-to-back read accepted next cycle
        cyc[0] = 1'b1; rd[0] = 1'b1; addr[0 +: BUS_AW] = 18'h1;
        @(negedge clk);
        check("R4 rdrs", 64'(rdrs), 64'h1);
        check("R4 ack", 64'(ack), 64'h1);
        addr[0 +: BUS_AW] = 18'h2;
        @(negedge clk);
        check("R4 second ack", 64'(ack), 64'h1);
        check("R4 second data", 64'(rdata), 64'h5_5555_5555);
        cyc[0] = 1'b0; rd[0] = 1'b0;
        @(negedge clk);
        check("R3 ack one cycle", 64'(ack), 64'h0);

        // R5: write with no data leaves zero
        req(0, 18'h9, 1'b0, 1'b1, ak, rr, d);
        data(0, '0, 1'b0, 1'b1);
        rd_word(0, 18'h9, d, ak);
        check("R5 cleared", 64'(d), 64'h0);

        // R6: accumulate two merges
        req(0, 18'h3, 1'b0, 1'b1, ak, rr, d);
        data(0, 36'hF_0000_0000, 1'b0, 1'b0);
        data(0, 36'h0_0000_00F0, 1'b0, 1'b1);
        rd_word(0, 18'h3, d, ak);
        check("R6 merged", 64'(d), 64'hF_0000_00F0);

        // R7: read-modify-write; held read suppresses merge
        req(0, 18'h3, 1'b1, 1'b1, ak, rr, d);
        check("R7 rdrs", 64'(rr), 64'h1);
        check("R7 old word", 64'(d), 64'hF_0000_00F0);
        data(0, 36'h0_1111_0000, 1'b1, 1'b0);
        data(0, 36'h0_0000_0022, 1'b0, 1'b1);
        rd_word(0, 18'h3, d, ak);
        check("R7 new word", 64'(d), 64'h0_0000_0022);

        // R2: upper bus address bits ignored
        wr_word(0, 18'h3_FF05, 36'h0_ABCD_0123);
        rd_word(0, 18'h0_0005, d, ak);
        check("R2 alias", 64'(d), 64'h0_ABCD_0123);

        // R8: request while active ignored; restart in idle harmless
        req(0, 18'h6, 1'b0, 1'b1, ak, rr, d);
        req(0, 18'h6, 1'b1, 1'b0, ak, rr, d);
        rd[0] = 1'b0;
        check("R8 busy no ack", 64'(ak), 64'h0);
        data(0, 36'h0_0000_0444, 1'b0, 1'b1);
        data(0, 36'h0_0000_0001, 1'b0, 1'b1);
        rd_word(0, 18'h6, d, ak);
        check("R8 ack after end", 64'(ak), 64'h1);
        check("R8 idle restart no effect", 64'(d), 64'h0_0000_0444);

        // R8: bare cycle holds until restart
        req(0, 18'h6, 1'b0, 1'b0, ak, rr, d);
        check("R8 bare ack", 64'(ak), 64'h1);
        req(0, 18'h6, 1'b1, 1'b0, ak, rr, d);
        rd[0] = 1'b0;
        check("R8 hold no ack", 64'(ak), 64'h0);
        data(0, '0, 1'b0, 1'b1);

        // R1: other port ignored
        req(2, 18'h4, 1'b0, 1'b1, ak, rr, d);
        check("R1 no ack other port", 64'(ak), 64'h0);
        data(2, 36'h0_0000_0FFF, 1'b0, 1'b1);
        rd_word(0, 18'h4, d, ak);
        check("R1 word untouched", 64'(d), 64'hA_AAAA_AAAA);
        port_sel = 2'd2;
        @(negedge clk);
        rd_word(2, 18'h4, d, ak);
        check("R1 ack on port 2", 64'(ak), 64'h4);
        check("R1 data on port 2", 64'(d), 64'hA_AAAA_AAAA);
        rd_word(0, 18'h4, d, ak);
        check("R1 port 0 ignored", 64'(ak), 64'h0);

        // R9: reset mid-cycle returns to idle
        req(2, 18'h4, 1'b0, 1'b1, ak, rr, d);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 ack low in reset", 64'(ack), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_word(2, 18'h4, d, ak);
        check("R9 idle after reset", 64'(ak), 64'h4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule